// File: doc/BRIEF.md
# Portal Call Domain Switcher

This block turns a call into a switch of protection domain without changing the running thread. When a call is presented, the block reads the rights that the protection lookup returns for the call target in the same cycle. If the target grants the portal right, the block fetches a one-line descriptor. The descriptor gives an entry address, a target domain ID and the target's well-known region registers. The block pushes the caller's domain ID, region registers and return address onto a private save stack. It then installs the descriptor's domain and regions and announces a jump to the entry address. A target with only the execute right gives an ordinary call. A target with neither right gives a fault.

A portal return pops the newest saved context, reinstalls it and jumps back to the saved return address. The save stack has no read or write path to software. Its contents can only come back out through a portal return. The thread identity is never touched: the only context swapped is the domain ID and the region registers. The install is announced on a swap strobe beside the current-context outputs, which feed the fast region checker.

Top module: `portal_switch`

## Requirements
- R1: After reset `busy`, `jump_valid`, `fault_valid`, `swap_valid` and `desc_req_valid` are low, `cur_domain` equals the root domain (0 by default) and `cur_regions` is all zeros.
- R2: An accepted call whose target has `perm_exec`=1 and `perm_portal`=0 gives, on the next cycle, `jump_valid`=1 with `jump_kind`=0 (plain call) and `jump_addr` equal to the target. There is no swap and the context is unchanged.
- R3: An accepted call whose target has neither right gives, on the next cycle, `fault_valid`=1 with `fault_code`=1 (no execute). No jump is produced and the context is unchanged.
- R4: An accepted call with `perm_portal`=1 and a save stack that is not full raises `desc_req_valid` on the next cycle, with `desc_req_addr` equal to the target. The request is held stable until `desc_req_ready` is seen. `busy` stays high from the cycle after acceptance until the new domain is installed.
- R5: In the cycle after `desc_rsp_valid`, `cur_domain` and `cur_regions` hold the descriptor's values. In that same cycle `swap_valid`=1 and `jump_valid`=1 with `jump_kind`=1 (portal entry) and `jump_addr` equal to the descriptor entry address. `busy` is low in that cycle.
- R6: An accepted portal return with a non-empty save stack gives, on the next cycle, `jump_valid`=1 with `jump_kind`=2 (return) and `jump_addr` equal to the saved return address. In that cycle the saved domain and regions are reinstalled and `swap_valid`=1.
- R7: Nested portal calls unwind in last-in first-out order. Each return restores the context that was current just before the matching call, up to a nesting depth of DEPTH (8).
- R8: A portal call while DEPTH contexts are saved gives `fault_valid`=1 with `fault_code`=2 (overflow) on the next cycle. No descriptor is requested and no state changes.
- R9: A portal return with an empty save stack gives `fault_valid`=1 with `fault_code`=3 (underflow) on the next cycle, with no change to the context.
- R10: While `busy` is high, `call_valid` and `ret_valid` are ignored. When both are asserted while idle, the call is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_valid | input | 1 | Call request this cycle |
| call_target | input | ADDR_W | Call target address |
| call_ret_addr | input | ADDR_W | Return address of the caller |
| ret_valid | input | 1 | Portal return request this cycle |
| perm_exec | input | 1 | Lookup result for call_target: execute right |
| perm_portal | input | 1 | Lookup result for call_target: portal right |
| busy | output | 1 | Portal sequence in progress |
| desc_req_valid | output | 1 | Descriptor fetch request |
| desc_req_ready | input | 1 | Fetch request accepted |
| desc_req_addr | output | ADDR_W | Descriptor line address |
| desc_rsp_valid | input | 1 | Descriptor data valid |
| desc_rsp_entry | input | ADDR_W | Descriptor entry address |
| desc_rsp_domain | input | DOM_W | Descriptor target domain ID |
| desc_rsp_regions | input | NREG*2*ADDR_W | Descriptor well-known region bounds |
| swap_valid | output | 1 | New context installed this cycle |
| cur_domain | output | DOM_W | Current domain ID |
| cur_regions | output | NREG*2*ADDR_W | Current well-known region bounds |
| jump_valid | output | 1 | Control transfer this cycle |
| jump_addr | output | ADDR_W | Transfer target |
| jump_kind | output | 2 | 0 call, 1 portal entry, 2 return |
| fault_valid | output | 1 | Fault this cycle |
| fault_code | output | 2 | 1 no execute, 2 overflow, 3 underflow |

## Verification
Some properties are checked on every cycle. A fault never comes with a jump or a swap, and it leaves the context as it was. A pending descriptor request stays stable. A swap always comes with a portal-entry or return jump, in an idle cycle. A plain call never alters the domain. Requests made while busy never produce a call or a fault. The bench scenarios are needed for the values themselves: that the installed domain and regions match the descriptor, that nested returns unwind in the right order, and that the overflow and underflow boundaries fall at exactly DEPTH and zero.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [1:0] {
    JK_CALL   = 2'd0,
    JK_PORTAL = 2'd1,
    JK_RETURN = 2'd2
  } jump_kind_e;

  typedef enum logic [1:0] {
    FC_NONE      = 2'd0,
    FC_NOEXEC    = 2'd1,
    FC_OVERFLOW  = 2'd2,
    FC_UNDERFLOW = 2'd3
  } fault_code_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pcs_save_stack.sv
module pcs_save_stack #(
  parameter int ENTRY_W = 64,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_en,
  input  logic               pop_en,
  input  logic [ENTRY_W-1:0] push_data,
  output logic [ENTRY_W-1:0] top_data,
  output logic               full,
  output logic               empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   top_cnt;

  assign top_cnt  = cnt_q - CNT_W'(1);
  assign top_data = mem[top_cnt[IDX_W-1:0]];
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign empty    = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (push_en && !full)      cnt_d = cnt_q + CNT_W'(1);
    else if (pop_en && !empty) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push_en && !full) mem[cnt_q[IDX_W-1:0]] <= push_data;
  end
endmodule

// File: rtl/pcs_ctx_reg.sv
module pcs_ctx_reg #(
  parameter int              DOM_W    = 8,
  parameter int              NREG     = 3,
  parameter int              REG_W    = 64,
  parameter logic [DOM_W-1:0] ROOT_DOM = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic [DOM_W-1:0]      load_dom,
  input  logic [NREG*REG_W-1:0] load_regs,
  output logic [DOM_W-1:0]      cur_dom,
  output logic [NREG*REG_W-1:0] cur_regs
);
  logic [DOM_W-1:0] dom_q, dom_d;

  always_comb dom_d = load_en ? load_dom : dom_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dom_q <= ROOT_DOM;
    else        dom_q <= dom_d;
  end
  assign cur_dom = dom_q;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    logic [REG_W-1:0] rg_q, rg_d;
    always_comb rg_d = load_en ? load_regs[g*REG_W +: REG_W] : rg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rg_q <= '0;
      else        rg_q <= rg_d;
    end
    assign cur_regs[g*REG_W +: REG_W] = rg_q;
  end
endmodule

// File: rtl/pcs_sequencer.sv
module pcs_sequencer
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_valid,
  input  logic [ADDR_W-1:0] call_target,
  input  logic [ADDR_W-1:0] call_ret_addr,
  input  logic              ret_valid,
  input  logic              perm_exec,
  input  logic              perm_portal,
  input  logic              stk_full,
  input  logic              stk_empty,
  input  logic [ADDR_W-1:0] stk_ret_addr,
  input  logic              desc_req_ready,
  input  logic              desc_rsp_valid,
  input  logic [ADDR_W-1:0] desc_rsp_entry,
  output logic              desc_req_valid,
  output logic [ADDR_W-1:0] desc_req_addr,
  output logic              busy,
  output logic              push_en,
  output logic              pop_en,
  output logic              ctx_load,
  output logic              ctx_from_desc,
  output logic [ADDR_W-1:0] saved_ret_addr,
  output logic              jump_valid,
  output logic [ADDR_W-1:0] jump_addr,
  output logic [1:0]        jump_kind,
  output logic              fault_valid,
  output logic [1:0]        fault_code,
  output logic              swap_valid
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d, ret_q, ret_d;
  logic              jv_q, jv_d, fv_q, fv_d, sv_q, sv_d;
  logic [ADDR_W-1:0] ja_q, ja_d;
  jump_kind_e        jk_q, jk_d;
  fault_code_e       fc_q, fc_d;

  always_comb begin
    state_d       = state_q;
    tgt_d         = tgt_q;
    ret_d         = ret_q;
    jv_d          = 1'b0;
    ja_d          = ja_q;
    jk_d          = jk_q;
    fv_d          = 1'b0;
    fc_d          = fc_q;
    sv_d          = 1'b0;
    push_en       = 1'b0;
    pop_en        = 1'b0;
    ctx_load      = 1'b0;
    ctx_from_desc = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (call_valid) begin
          if (perm_portal) begin
            if (stk_full) begin
              fv_d = 1'b1;
              fc_d = FC_OVERFLOW;
            end else begin
              state_d = SQ_REQ;
              tgt_d   = call_target;
              ret_d   = call_ret_addr;
            end
          end else if (perm_exec) begin
            jv_d = 1'b1;
            ja_d = call_target;
            jk_d = JK_CALL;
          end else begin
            fv_d = 1'b1;
            fc_d = FC_NOEXEC;
          end
        end else if (ret_valid) begin
          if (stk_empty) begin
            fv_d = 1'b1;
            fc_d = FC_UNDERFLOW;
          end else begin
            pop_en   = 1'b1;
            ctx_load = 1'b1;
            jv_d     = 1'b1;
            ja_d     = stk_ret_addr;
            jk_d     = JK_RETURN;
            sv_d     = 1'b1;
          end
        end
      end
      SQ_REQ: begin
        if (desc_req_ready) state_d = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (desc_rsp_valid) begin
          push_en       = 1'b1;
          ctx_load      = 1'b1;
          ctx_from_desc = 1'b1;
          jv_d          = 1'b1;
          ja_d          = desc_rsp_entry;
          jk_d          = JK_PORTAL;
          sv_d          = 1'b1;
          state_d       = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      tgt_q   <= '0;
      ret_q   <= '0;
      jv_q    <= 1'b0;
      ja_q    <= '0;
      jk_q    <= JK_CALL;
      fv_q    <= 1'b0;
      fc_q    <= FC_NONE;
      sv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      ret_q   <= ret_d;
      jv_q    <= jv_d;
      ja_q    <= ja_d;
      jk_q    <= jk_d;
      fv_q    <= fv_d;
      fc_q    <= fc_d;
      sv_q    <= sv_d;
    end
  end

  assign desc_req_valid = (state_q == SQ_REQ);
  assign desc_req_addr  = tgt_q;
  assign busy           = (state_q != SQ_IDLE);
  assign saved_ret_addr = ret_q;
  assign jump_valid     = jv_q;
  assign jump_addr      = ja_q;
  assign jump_kind      = jk_q;
  assign fault_valid    = fv_q;
  assign fault_code     = fc_q;
  assign swap_valid     = sv_q;
endmodule

// File: rtl/portal_switch.sv
module portal_switch #(
  parameter int              ADDR_W   = 32,
  parameter int              DOM_W    = 8,
  parameter int              NREG     = 3,
  parameter int              DEPTH    = 8,
  parameter logic [DOM_W-1:0] ROOT_DOM = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       call_valid,
  input  logic [ADDR_W-1:0]          call_target,
  input  logic [ADDR_W-1:0]          call_ret_addr,
  input  logic                       ret_valid,
  input  logic                       perm_exec,
  input  logic                       perm_portal,
  output logic                       busy,
  output logic                       desc_req_valid,
  input  logic                       desc_req_ready,
  output logic [ADDR_W-1:0]          desc_req_addr,
  input  logic                       desc_rsp_valid,
  input  logic [ADDR_W-1:0]          desc_rsp_entry,
  input  logic [DOM_W-1:0]           desc_rsp_domain,
  input  logic [NREG*2*ADDR_W-1:0]   desc_rsp_regions,
  output logic                       swap_valid,
  output logic [DOM_W-1:0]           cur_domain,
  output logic [NREG*2*ADDR_W-1:0]   cur_regions,
  output logic                       jump_valid,
  output logic [ADDR_W-1:0]          jump_addr,
  output logic [1:0]                 jump_kind,
  output logic                       fault_valid,
  output logic [1:0]                 fault_code
);
  localparam int REG_W   = 2 * ADDR_W;
  localparam int REGS_W  = NREG * REG_W;
  localparam int ENTRY_W = DOM_W + REGS_W + ADDR_W;

  logic               push_en, pop_en, stk_full, stk_empty;
  logic               ctx_load, ctx_from_desc;
  logic [ADDR_W-1:0]  saved_ret_addr;
  logic [ENTRY_W-1:0] push_data, top_data;
  logic [DOM_W-1:0]   top_dom, load_dom;
  logic [REGS_W-1:0]  top_regs, load_regs;
  logic [ADDR_W-1:0]  top_ret;

  assign push_data = {cur_domain, cur_regions, saved_ret_addr};
  assign {top_dom, top_regs, top_ret} = top_data;
  assign load_dom  = ctx_from_desc ? desc_rsp_domain  : top_dom;
  assign load_regs = ctx_from_desc ? desc_rsp_regions : top_regs;

  pcs_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst_n, .call_valid, .call_target, .call_ret_addr, .ret_valid,
    .perm_exec, .perm_portal, .stk_full, .stk_empty,
    .stk_ret_addr(top_ret), .desc_req_ready, .desc_rsp_valid, .desc_rsp_entry,
    .desc_req_valid, .desc_req_addr, .busy, .push_en, .pop_en,
    .ctx_load, .ctx_from_desc, .saved_ret_addr,
    .jump_valid, .jump_addr, .jump_kind, .fault_valid, .fault_code, .swap_valid
  );

  pcs_save_stack #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_stack (
    .clk, .rst_n, .push_en, .pop_en, .push_data, .top_data,
    .full(stk_full), .empty(stk_empty)
  );

  pcs_ctx_reg #(.DOM_W(DOM_W), .NREG(NREG), .REG_W(REG_W), .ROOT_DOM(ROOT_DOM)) u_ctx (
    .clk, .rst_n, .load_en(ctx_load), .load_dom, .load_regs,
    .cur_dom(cur_domain), .cur_regs(cur_regions)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int ADDR_W = 32,
  parameter int DOM_W  = 8,
  parameter int REGS_W = 192
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              desc_req_valid,
  input logic              desc_req_ready,
  input logic [ADDR_W-1:0] desc_req_addr,
  input logic              swap_valid,
  input logic [DOM_W-1:0]  cur_domain,
  input logic [REGS_W-1:0] cur_regions,
  input logic              jump_valid,
  input logic [1:0]        jump_kind,
  input logic              fault_valid,
  input logic [1:0]        fault_code
);
  // R3
  no_jump_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (!jump_valid && !swap_valid && fault_code != 2'd0));

  // R8
  fault_keeps_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (cur_domain == $past(cur_domain) && cur_regions == $past(cur_regions)));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req_valid && !desc_req_ready) |=> (desc_req_valid && $stable(desc_req_addr)));

  // R5
  swap_with_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_valid |-> (jump_valid && jump_kind != 2'd0 && !busy));

  // R2
  call_no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_valid && jump_kind == 2'd0) |-> (!swap_valid && $stable(cur_domain)));

  // R10
  busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(jump_valid && jump_kind == 2'd0) && !fault_valid);
endmodule

bind portal_switch pcs_checker #(.ADDR_W(ADDR_W), .DOM_W(DOM_W), .REGS_W(NREG*2*ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .desc_req_valid(desc_req_valid),
  .desc_req_ready(desc_req_ready), .desc_req_addr(desc_req_addr),
  .swap_valid(swap_valid), .cur_domain(cur_domain), .cur_regions(cur_regions),
  .jump_valid(jump_valid), .jump_kind(jump_kind),
  .fault_valid(fault_valid), .fault_code(fault_code)
);

// File: tb/portal_switch_bench.sv
module portal_switch_bench;
  localparam int ADDR_W = 32;
  localparam int DOM_W  = 8;
  localparam int NREG   = 3;
  localparam int DEPTH  = 8;
  localparam int REGS_W = NREG * 2 * ADDR_W;

  logic clk = 1'b0;
  logic rst_n;
  logic call_valid, ret_valid, perm_exec, perm_portal;
  logic [ADDR_W-1:0] call_target, call_ret_addr;
  logic busy, desc_req_valid, desc_req_ready, desc_rsp_valid;
  logic [ADDR_W-1:0] desc_req_addr, desc_rsp_entry, jump_addr;
  logic [DOM_W-1:0]  desc_rsp_domain, cur_domain;
  logic [REGS_W-1:0] desc_rsp_regions, cur_regions;
  logic swap_valid, jump_valid, fault_valid;
  logic [1:0] jump_kind, fault_code;

  always #2 clk = ~clk;

  portal_switch u_portal_switch (
    .clk, .rst_n, .call_valid, .call_target, .call_ret_addr, .ret_valid,
    .perm_exec, .perm_portal, .busy, .desc_req_valid, .desc_req_ready,
    .desc_req_addr, .desc_rsp_valid, .desc_rsp_entry, .desc_rsp_domain,
    .desc_rsp_regions, .swap_valid, .cur_domain, .cur_regions,
    .jump_valid, .jump_addr, .jump_kind, .fault_valid, .fault_code
  );

  typedef struct {
    bit                is_fault;
    logic [1:0]        code;
    logic [ADDR_W-1:0] addr;
    logic [DOM_W-1:0]  dom;
    logic [REGS_W-1:0] regs;
  } exp_t;

  exp_t exp_q[$];
  int tests = 0;
  int fails = 0;
  logic [DOM_W-1:0]  m_dom;
  logic [REGS_W-1:0] m_regs;
  logic [DOM_W-1:0]  s_dom[$];
  logic [REGS_W-1:0] s_regs[$];
  logic [ADDR_W-1:0] s_ret[$];

  task automatic check(input string tag, input string what,
                       input logic [REGS_W-1:0] act, input logic [REGS_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DOM_W-1:0] d_dom(input logic [ADDR_W-1:0] t);
    return DOM_W'(t ^ (t >> 8) ^ 32'h3C);
  endfunction
  function automatic logic [REGS_W-1:0] d_regs(input logic [ADDR_W-1:0] t);
    logic [REGS_W-1:0] r;
    for (int i = 0; i < 2*NREG; i++) r[i*ADDR_W +: ADDR_W] = t * (i + 3) ^ ADDR_W'(i);
    return r;
  endfunction
  function automatic logic [ADDR_W-1:0] d_entry(input logic [ADDR_W-1:0] t);
    return t + 32'h0000_0400;
  endfunction

  // monitor: every jump or fault must match the oldest expected item
  always @(negedge clk) begin
    if (rst_n === 1'b1 && (jump_valid === 1'b1 || fault_valid === 1'b1)) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R10 unexpected output: actual jump=%0b fault=%0b expected none",
                 jump_valid, fault_valid);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.is_fault) begin
          check("R3", "fault_valid", REGS_W'(fault_valid), 1);
          check("R8", "fault_code", REGS_W'(fault_code), REGS_W'(e.code));
          check("R9", "swap_valid on fault", REGS_W'(swap_valid), 0);
        end else begin
          check("R2", "jump_valid", REGS_W'(jump_valid), 1);
          check("R5", "jump_kind", REGS_W'(jump_kind), REGS_W'(e.code));
          check("R6", "jump_addr", REGS_W'(jump_addr), REGS_W'(e.addr));
          check("R5", "swap_valid", REGS_W'(swap_valid), REGS_W'(e.code != 2'd0));
        end
        check("R7", "cur_domain", REGS_W'(cur_domain), REGS_W'(e.dom));
        check("R7", "cur_regions", cur_regions, e.regs);
      end
    end
  end

  task automatic push_exp(input bit f, input logic [1:0] c, input logic [ADDR_W-1:0] a);
    exp_t e;
    e.is_fault = f; e.code = c; e.addr = a; e.dom = m_dom; e.regs = m_regs;
    exp_q.push_back(e);
  endtask

  task automatic do_call(input logic [ADDR_W-1:0] t, input logic [ADDR_W-1:0] r,
                         input bit ex, input bit po, input bit noise);
    if (po && s_dom.size() >= DEPTH) push_exp(1'b1, 2'd2, '0);      // R8
    else if (!po && ex)               push_exp(1'b0, 2'd0, t);      // R2
    else if (!po)                     push_exp(1'b1, 2'd1, '0);     // R3
    call_valid = 1'b1; call_target = t; call_ret_addr = r;
    perm_exec = ex; perm_portal = po;
    @(negedge clk);
    call_valid = 1'b0; perm_exec = 1'b0; perm_portal = 1'b0;
    if (po && s_dom.size() >= DEPTH) begin
      check("R8", "no descriptor request when full", REGS_W'(desc_req_valid), 0);
    end else if (po) begin
      check("R4", "desc_req_valid", REGS_W'(desc_req_valid), 1);
      check("R4", "desc_req_addr", REGS_W'(desc_req_addr), REGS_W'(t));
      check("R4", "busy during fetch", REGS_W'(busy), 1);
      if (noise) begin
        call_valid = 1'b1; ret_valid = 1'b1; perm_exec = 1'b1; call_target = 32'hDEAD_0000;
      end
      @(negedge clk);
      call_valid = 1'b0; ret_valid = 1'b0; perm_exec = 1'b0;
      check("R4", "request held without ready", REGS_W'(desc_req_valid), 1);
      check("R10", "request addr unchanged by ignored call", REGS_W'(desc_req_addr), REGS_W'(t));
      desc_req_ready = 1'b1;
      @(negedge clk);
      desc_req_ready = 1'b0;
      check("R4", "request dropped after ready", REGS_W'(desc_req_valid), 0);
      check("R4", "busy while waiting", REGS_W'(busy), 1);
      s_dom.push_back(m_dom); s_regs.push_back(m_regs); s_ret.push_back(r);
      m_dom = d_dom(t); m_regs = d_regs(t);
      push_exp(1'b0, 2'd1, d_entry(t));                              // R5
      desc_rsp_valid = 1'b1; desc_rsp_entry = d_entry(t);
      desc_rsp_domain = d_dom(t); desc_rsp_regions = d_regs(t);
      @(negedge clk);
      desc_rsp_valid = 1'b0;
      check("R5", "busy low once installed", REGS_W'(busy), 0);
    end
  endtask

  task automatic do_ret();
    if (s_dom.size() == 0) push_exp(1'b1, 2'd3, '0);                // R9
    else begin
      logic [ADDR_W-1:0] ra;
      m_dom = s_dom.pop_back(); m_regs = s_regs.pop_back(); ra = s_ret.pop_back();
      push_exp(1'b0, 2'd2, ra);                                     // R6
    end
    ret_valid = 1'b1;
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic finish_run();
    check("R10", "all expected outputs seen", REGS_W'(exp_q.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    call_valid = 1'b0; ret_valid = 1'b0; perm_exec = 1'b0; perm_portal = 1'b0;
    call_target = '0; call_ret_addr = '0;
    desc_req_ready = 1'b0; desc_rsp_valid = 1'b0;
    desc_rsp_entry = '0; desc_rsp_domain = '0; desc_rsp_regions = '0;
    m_dom = '0; m_regs = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "busy", REGS_W'(busy), 0);
    check("R1", "jump_valid", REGS_W'(jump_valid), 0);
    check("R1", "fault_valid", REGS_W'(fault_valid), 0);
    check("R1", "swap_valid", REGS_W'(swap_valid), 0);
    check("R1", "desc_req_valid", REGS_W'(desc_req_valid), 0);
    check("R1", "cur_domain", REGS_W'(cur_domain), 0);
    check("R1", "cur_regions", cur_regions, 0);

    do_call(32'h0000_1000, 32'h10, 1'b1, 1'b0, 1'b0);   // R2
    do_call(32'hFFFF_FFF0, 32'h14, 1'b1, 1'b0, 1'b0);   // R2
    do_call(32'h0000_2000, 32'h18, 1'b0, 1'b0, 1'b0);   // R3
    do_ret();                                            // R9 empty
    do_call(32'h0040_0000, 32'h1C, 1'b1, 1'b1, 1'b1);   // R4 R5 R10 noise
    // R10: call and return together while idle, call wins
    push_exp(1'b0, 2'd0, 32'h0000_3000);
    call_valid = 1'b1; ret_valid = 1'b1; perm_exec = 1'b1;
    call_target = 32'h0000_3000;
    @(negedge clk);
    call_valid = 1'b0; ret_valid = 1'b0; perm_exec = 1'b0;
    do_ret();                                            // R6 back to root
    // R7 nesting to full depth, R8 overflow
    for (int i = 0; i < DEPTH; i++)
      do_call(32'h0100_0000 + 32'h40 * i, 32'h200 + i, 1'b0, 1'b1, 1'b0);
    do_call(32'h0F00_0000, 32'h300, 1'b1, 1'b1, 1'b0);  // R8
    for (int i = 0; i < DEPTH; i++) do_ret();           // R7 LIFO
    do_ret();                                            // R9
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule